// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a single device. It runs the sixteen-state test state machine on the test clock, holds a four-bit instruction register, and decodes the active instruction into a choice of one serial path between the test data input and the test data output. The three paths are a 32-bit identification register, a one-bit bypass register, and an external boundary-scan chain. The chain is reached through a serial-in, a serial-out and three strobes.

The decoded instruction also drives three pin-mode controls for the boundary cells. One makes the output pins take their values from the boundary register. One holds those values for a clamp. One turns every pin output driver off. After any reset the instruction is the identification read. None of the pin-mode controls is active then, so functional pins run straight through to the core.

The state machine can be reset in two ways. Pulling the active-low test reset low resets it at once. Five test-clock rising edges with the mode input high also bring it to its reset state, whatever state it started in.

Top module: `scan_tap`

## Requirements
- R1: The state machine follows the standard sixteen-state test graph on rising edges of `tck`, steered by `tms`. Data scans enter through Select-DR, Capture-DR and Shift-DR. Instruction scans enter through Select-IR, Capture-IR and Shift-IR.
- R2: While `trst_n` is low, the block is held in Test-Logic-Reset at once, without waiting for a clock. In that condition `tdo_oe` is 0, the instruction is IDCODE (0101), and `pins_from_chain`, `pins_clamp` and `pins_float` are all 0.
- R3: Five consecutive rising edges of `tck` with `tms` = 1 reach Test-Logic-Reset from any state. On the next falling edge the instruction becomes IDCODE (0101).
- R4: In Capture-IR the instruction shift register loads 0001. In Shift-IR it shifts toward bit 0: `tdi` enters bit 3 and bit 0 is presented on `tdo`. The active instruction takes the shifted value on the falling edge of `tck` in Update-IR, and at no other time except reset.
- R5: The instruction codes are EXTEST = 0000, SAMPLE = 0001, IDCODE = 0101, CLAMP = 0110, HIGHZ = 0111 and BYPASS = 1111. EXTEST and SAMPLE select the boundary chain. IDCODE selects the identification register. BYPASS, CLAMP and HIGHZ select the bypass register.
- R6: Any other instruction code behaves exactly as BYPASS: it selects the bypass path and activates no pin-mode control.
- R7: The identification register is `ID_W` bits wide and is shifted out least significant bit first. In Capture-DR it loads `ID_VALUE` with bit 0 forced to 1.
- R8: In Capture-DR the bypass register loads 0. A bypass scan therefore returns a 0 first and then each `tdi` bit one shift later.
- R9: `tdo` and `tdo_oe` change only on falling edges of `tck`. `tdo_oe` is 1 only after a falling edge in Shift-IR or Shift-DR.
- R10: While the chain is selected, `chain_capture` is high in Capture-DR, `chain_shift` in Shift-DR and `chain_update` in Update-DR. The chain output `chain_so` is what appears on `tdo` during Shift-DR. With any other path selected all three strobes stay low. `chain_si` always follows `tdi`.
- R11: `pins_from_chain` is 1 for EXTEST and CLAMP. `pins_clamp` is 1 only for CLAMP. `pins_float` is 1 only for HIGHZ. SAMPLE, IDCODE and BYPASS leave all three at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| chain_so | input | 1 | Serial output of the external boundary chain |
| chain_si | output | 1 | Serial input to the boundary chain |
| chain_capture | output | 1 | Boundary cells load pin states on next rising `tck` |
| chain_shift | output | 1 | Boundary cells shift one place on next rising `tck` |
| chain_update | output | 1 | Boundary cells move shifted data to their hold stage |
| pins_from_chain | output | 1 | Output pins take values from the boundary register |
| pins_clamp | output | 1 | Boundary hold stage keeps its preloaded values |
| pins_float | output | 1 | All pin output drivers disabled |

## Verification
The bench first checks that a code outside the six defined ones falls back to the bypass path. A design that got this wrong would put the ID register or the chain on `tdo`, or would set a pin-mode control. It then checks the instant at which `pins_float` and `tdo_oe` change. A design that updated them on the rising edge would show them one half-cycle early. The synchronous reset is tried from Pause-DR and from Pause-IR; the second route passes through Update-IR, so a design that let that update win over the reset would be left holding SAMPLE instead of IDCODE. The last check pulls reset low in the middle of a data shift. A design with a reset on the clock would keep `tdo_oe` high and keep the old instruction.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHF_DR,
        ST_EX1_DR,
        ST_PAU_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHF_IR,
        ST_EX1_IR,
        ST_PAU_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0101;
    localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0110;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0111;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        PATH_ID,
        PATH_BYPASS,
        PATH_CHAIN
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     from_chain;
        logic     clamp;
        logic     float_out;
    } decode_t;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RESET:  r_d.st = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r_d.st = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r_d.st = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: r_d.st = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: r_d.st = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r_d.st = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r_d.st = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r_d.st = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: r_d.st = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: r_d.st = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: r_d.st = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r_d.st = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r_d.st = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: r_d.st = tms ? ST_SEL_DR : ST_IDLE;
            default:   r_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            r_q <= '{st: ST_RESET};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

    // Run length of tms high, kept only for the checks below
    logic [2:0] tms_run_q;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tms_run_q <= 3'd0;
        end else if (!tms) begin
            tms_run_q <= 3'd0;
        end else if (tms_run_q != 3'd5) begin
            tms_run_q <= tms_run_q + 3'd1;
        end
    end

    AST_FIVE_HIGH_RESETS: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run_q == 3'd5) |-> (r_q.st == ST_RESET)); // R3

    AST_SHIFT_DR_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
        (r_q.st == ST_SHF_DR) |-> ($past(r_q.st) == ST_CAP_DR ||
                                   $past(r_q.st) == ST_SHF_DR ||
                                   $past(r_q.st) == ST_EX2_DR)); // R1

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  tap_state_e      state_i,
    output logic [IR_W-1:0] ir_o,
    output logic            ir_so_o
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
    } ir_shift_t;

    typedef struct packed {
        logic [IR_W-1:0] act;
    } ir_hold_t;

    ir_shift_t sh_d, sh_q;
    ir_hold_t  hd_d, hd_q;

    // Capture and shift on the rising edge
    always_comb begin
        sh_d = sh_q;
        if (state_i == ST_CAP_IR) begin
            sh_d.sr = IR_CAPTURE;
        end else if (state_i == ST_SHF_IR) begin
            sh_d.sr = {tdi, sh_q.sr[IR_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '{sr: IR_CAPTURE};
        end else begin
            sh_q <= sh_d;
        end
    end

    // Active instruction moves on the falling edge
    always_comb begin
        hd_d = hd_q;
        if (state_i == ST_RESET) begin
            hd_d.act = OP_IDCODE;
        end else if (state_i == ST_UPD_IR) begin
            hd_d.act = sh_q.sr;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            hd_q <= '{act: OP_IDCODE};
        end else begin
            hd_q <= hd_d;
        end
    end

    assign ir_o    = hd_q.act;
    assign ir_so_o = sh_q.sr[0];

    AST_IR_HOLDS_OUTSIDE_UPDATE: assert property (@(negedge tck) disable iff (!trst_n)
        (state_i != ST_UPD_IR && state_i != ST_RESET) |=> $stable(hd_q.act)); // R4

    AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_IR) |=> (sh_q.sr == IR_CAPTURE)); // R4

endmodule

// File: rtl/scan_tap_decode.sv
module scan_tap_decode
    import scan_tap_pkg::*;
(
    input  logic [IR_W-1:0] ir_i,
    output decode_t         dec_o
);

    always_comb begin
        dec_o = '{path: PATH_BYPASS, from_chain: 1'b0, clamp: 1'b0, float_out: 1'b0};
        case (ir_i)
            OP_EXTEST: begin
                dec_o.path       = PATH_CHAIN;
                dec_o.from_chain = 1'b1;
            end
            OP_SAMPLE: begin
                dec_o.path = PATH_CHAIN;
            end
            OP_IDCODE: begin
                dec_o.path = PATH_ID;
            end
            OP_CLAMP: begin
                dec_o.from_chain = 1'b1;
                dec_o.clamp      = 1'b1;
            end
            OP_HIGHZ: begin
                dec_o.float_out = 1'b1;
            end
            default: begin
                dec_o.path = PATH_BYPASS;
            end
        endcase
    end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0B57_6A2D
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_e state_i,
    input  dr_path_e   path_i,
    input  logic       ir_so_i,
    input  logic       chain_so_i,
    output logic       tdo_o,
    output logic       tdo_oe_o
);

    localparam logic [ID_W-1:0] ID_CAPTURE = {ID_VALUE[ID_W-1:1], 1'b1};

    typedef struct packed {
        logic [ID_W-1:0] id_sr;
        logic            byp;
    } dr_shift_t;

    typedef struct packed {
        logic tdo;
        logic oe;
    } dr_out_t;

    dr_shift_t sh_d, sh_q;
    dr_out_t   out_d, out_q;

    always_comb begin
        sh_d = sh_q;
        if (state_i == ST_CAP_DR) begin
            if (path_i == PATH_ID)     sh_d.id_sr = ID_CAPTURE;
            if (path_i == PATH_BYPASS) sh_d.byp   = 1'b0;
        end else if (state_i == ST_SHF_DR) begin
            if (path_i == PATH_ID)     sh_d.id_sr = {tdi, sh_q.id_sr[ID_W-1:1]};
            if (path_i == PATH_BYPASS) sh_d.byp   = tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '{id_sr: ID_CAPTURE, byp: 1'b0};
        end else begin
            sh_q <= sh_d;
        end
    end

    // Serial output, retimed to the falling edge
    always_comb begin
        out_d    = out_q;
        out_d.oe = 1'b0;
        if (state_i == ST_SHF_IR) begin
            out_d.tdo = ir_so_i;
            out_d.oe  = 1'b1;
        end else if (state_i == ST_SHF_DR) begin
            out_d.oe = 1'b1;
            case (path_i)
                PATH_ID:    out_d.tdo = sh_q.id_sr[0];
                PATH_CHAIN: out_d.tdo = chain_so_i;
                default:    out_d.tdo = sh_q.byp;
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            out_q <= '{tdo: 1'b0, oe: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign tdo_o    = out_q.tdo;
    assign tdo_oe_o = out_q.oe;

    AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe_o |-> (state_i == ST_SHF_DR || state_i == ST_SHF_IR)); // R9

    AST_ID_LSB_SET: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && path_i == PATH_ID) |=> sh_q.id_sr[0]); // R7

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == ST_CAP_DR && path_i == PATH_BYPASS) |=> !sh_q.byp); // R8

endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0B57_6A2D
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    input  logic chain_so,
    output logic chain_si,
    output logic chain_capture,
    output logic chain_shift,
    output logic chain_update,
    output logic pins_from_chain,
    output logic pins_clamp,
    output logic pins_float
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_act;
    logic            ir_so;
    decode_t         dec;
    logic            chain_sel;

    scan_tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    scan_tap_ir u_ir (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state_i (state),
        .ir_o    (ir_act),
        .ir_so_o (ir_so)
    );

    scan_tap_decode u_dec (
        .ir_i  (ir_act),
        .dec_o (dec)
    );

    scan_tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .state_i    (state),
        .path_i     (dec.path),
        .ir_so_i    (ir_so),
        .chain_so_i (chain_so),
        .tdo_o      (tdo),
        .tdo_oe_o   (tdo_oe)
    );

    assign chain_sel       = (dec.path == PATH_CHAIN);
    assign chain_si        = tdi;
    assign chain_capture   = chain_sel && (state == ST_CAP_DR);
    assign chain_shift     = chain_sel && (state == ST_SHF_DR);
    assign chain_update    = chain_sel && (state == ST_UPD_DR);
    assign pins_from_chain = dec.from_chain;
    assign pins_clamp      = dec.clamp;
    assign pins_float      = dec.float_out;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({chain_capture, chain_shift, chain_update})); // R10

    AST_PINS_NORMAL_AFTER_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET && $past(state) == ST_RESET)
            |-> !(pins_from_chain || pins_clamp || pins_float)); // R2

    AST_NO_CLAMP_WHILE_FLOAT: assert property (@(posedge tck) disable iff (!trst_n)
        pins_float |-> !pins_clamp && !pins_from_chain); // R11

endmodule

// File: tb/scan_tap_test.sv
`timescale 1ns/100ps
module scan_tap_test;

    localparam logic [31:0] ID_SET = 32'h1357_9BDE;
    localparam logic [31:0] ID_EXP = 32'h1357_9BDF;
    localparam logic [7:0]  PIN_STATES = 8'hA5;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe, chain_so, chain_si;
    logic chain_capture, chain_shift, chain_update;
    logic pins_from_chain, pins_clamp, pins_float;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit    exp_bit_q[$];
    string exp_tag_q[$];

    always #2 tck = ~tck;

    scan_tap #(.ID_W(32), .ID_VALUE(ID_SET)) uut (
        .tck             (tck),
        .trst_n          (trst_n),
        .tms             (tms),
        .tdi             (tdi),
        .tdo             (tdo),
        .tdo_oe          (tdo_oe),
        .chain_so        (chain_so),
        .chain_si        (chain_si),
        .chain_capture   (chain_capture),
        .chain_shift     (chain_shift),
        .chain_update    (chain_update),
        .pins_from_chain (pins_from_chain),
        .pins_clamp      (pins_clamp),
        .pins_float      (pins_float)
    );

    // Model of an eight-cell boundary chain
    logic [7:0] cell_sr  = 8'h00;
    logic [7:0] cell_upd = 8'h00;
    always @(posedge tck) begin
        if (chain_capture) cell_sr <= PIN_STATES;
        else if (chain_shift) cell_sr <= {chain_si, cell_sr[7:1]};
        if (chain_update) cell_upd <= cell_sr;
    end
    assign chain_so = cell_sr[0];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected bit for each shifted tdo bit
    initial begin
        forever begin
            @(negedge tck);
            #1;
            if (trst_n && tdo_oe) begin
                checks++;
                if (exp_bit_q.size() == 0) begin
                    fails++;
                    $display("FAIL R9 unexpected tdo bit actual=%b expected=none", tdo);
                end else begin
                    automatic bit    e = exp_bit_q.pop_front();
                    automatic string t = exp_tag_q.pop_front();
                    if (tdo !== e) begin
                        fails++;
                        $display("FAIL %s tdo actual=%b expected=%b", t, tdo, e);
                    end
                end
            end
        end
    end

    task automatic push(input bit b, input string tag);
        exp_bit_q.push_back(b);
        exp_tag_q.push_back(tag);
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #1.5;
    endtask

    // From Run-Test/Idle back to Run-Test/Idle
    task automatic shift_ir(input logic [3:0] code, input bit edge_chk);
        push(1'b1, "R4"); push(1'b0, "R4"); push(1'b0, "R4"); push(1'b0, "R4");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, code[i]);
        step(1, 0);
        if (edge_chk) begin
            #1.5;
            chk("R4 float before falling edge", {31'd0, pins_float}, 32'd0);
            @(negedge tck);
            #0.5;
            chk("R4 float after falling edge", {31'd0, pins_float}, 32'd1);
            tms = 1'b0;
        end else begin
            step(0, 0);
        end
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din,
                            input logic [63:0] dexp, input string tag);
        for (int i = 0; i < n; i++) push(dexp[i], tag);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 0); step(0, 0);
        settle();
        chk({tag, " queue drained"}, exp_bit_q.size(), 0);
    endtask

    function automatic logic [63:0] byp_exp(input logic [7:0] d);
        return {56'd0, d[6:0], 1'b0};
    endfunction

    function automatic logic [31:0] pins();
        return {29'd0, pins_from_chain, pins_clamp, pins_float};
    endfunction

    initial begin
        #10;
        chk("R2 oe in reset", {31'd0, tdo_oe}, 32'd0);
        chk("R2 pins in reset", pins(), 32'd0);
        @(negedge tck); #1; trst_n = 1'b1; tms = 1'b0;

        // Default instruction is IDCODE
        settle();
        shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R7");

        // BYPASS
        shift_ir(4'b1111, 1'b0);
        shift_dr(8, 64'hB2, byp_exp(8'hB2), "R8");
        chk("R5 bypass pins", pins(), 32'd0);

        // Undefined code
        shift_ir(4'b1010, 1'b0);
        chk("R6 undefined pins", pins(), 32'd0);
        shift_dr(8, 64'h6D, byp_exp(8'h6D), "R6");

        // EXTEST
        shift_ir(4'b0000, 1'b0);
        chk("R11 extest pins", pins(), 32'b100);
        shift_dr(8, 64'h3C, {56'd0, PIN_STATES}, "R10");
        chk("R10 chain update extest", {24'd0, cell_upd}, 32'h3C);

        // SAMPLE
        shift_ir(4'b0001, 1'b0);
        chk("R11 sample pins", pins(), 32'd0);
        shift_dr(8, 64'h96, {56'd0, PIN_STATES}, "R5");
        chk("R10 chain update sample", {24'd0, cell_upd}, 32'h96);

        // CLAMP
        shift_ir(4'b0110, 1'b0);
        chk("R11 clamp pins", pins(), 32'b110);
        shift_dr(8, 64'h4E, byp_exp(8'h4E), "R5");
        chk("R10 chain untouched under clamp", {24'd0, cell_upd}, 32'h96);

        // HIGHZ, with the update edge timing
        shift_ir(4'b0111, 1'b1);
        settle();
        chk("R11 highz pins", pins(), 32'b001);

        // oe timing on entry to Shift-DR
        push(1'b0, "R8");
        step(1, 0); step(0, 0); step(0, 0);
        #1.5;
        chk("R9 oe before falling edge", {31'd0, tdo_oe}, 32'd0);
        @(negedge tck);
        #0.5;
        chk("R9 oe after falling edge", {31'd0, tdo_oe}, 32'd1);
        tms = 1'b1;
        step(1, 0); step(0, 0);
        settle();
        chk("R9 oe in idle", {31'd0, tdo_oe}, 32'd0);

        // Synchronous reset from Pause-DR
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        settle();
        chk("R3 pins after tms reset", pins(), 32'd0);
        step(0, 0);
        shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R3");

        // Synchronous reset from Pause-IR, passing through Update-IR
        shift_ir(4'b1111, 1'b0);
        step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        step(0, 0);
        shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R3");

        // Asynchronous reset in mid shift
        shift_ir(4'b0000, 1'b0);
        chk("R11 extest again", pins(), 32'b100);
        push(PIN_STATES[0], "R10");
        step(1, 0); step(0, 0); step(0, 0);
        @(negedge tck);
        #1.5;
        trst_n = 1'b0;
        #1;
        chk("R2 oe on async reset", {31'd0, tdo_oe}, 32'd0);
        chk("R2 pins on async reset", pins(), 32'd0);
        @(negedge tck); #1; trst_n = 1'b1; tms = 1'b0;
        settle();
        shift_dr(32, 64'd0, {32'd0, ID_EXP}, "R2");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule